// File: doc/BRIEF.md
# Prefetch Issue Stage with Recent-Block Filter

This block holds a small in-order queue of pending prefetch operations and, every cycle, scans it from the oldest entry towards the youngest. It picks the prefetches that may go to the data-memory port in that cycle. An entry waits until its operands are ready. Enqueue can set the ready mark directly, or a later wakeup that carries the entry's tag can set it. A ready entry whose cache block was prefetched recently is pointless traffic. The block retires such an entry on the spot and reports it as completed, with no memory access. Any other ready entry is sent to memory, provided the port bank that serves its block can take it that cycle.

Each cycle has an issue budget of `ISSUE_W` requests, one lane each. Dropping a redundant entry does not cost budget. It does need one of `DROP_W` completion lanes. Every block address that is issued goes into a FIFO history of the last `HIST` issued blocks, and later lookups match against that history. Requests and completion notices are combinational outputs of the current queue state and the bank-accept inputs. The entries they name leave the queue at the next clock edge.

Top module: `pfq_issue_filter`

## Requirements
- R1: After reset the queue and the history are empty: `q_full`, `iss_valid` and `drop_valid` are all 0, even with every bank accepting.
- R2: An enqueue appends the entry at the tail when fewer than `DEPTH` entries are held. `q_full` is 1 exactly when `DEPTH` entries are held, and an enqueue while full is ignored.
- R3: An entry whose ready mark is 0 is passed over and stays queued. A `wake_valid` pulse sets the ready mark of every queued entry whose tag equals `wake_id`, and the entry is eligible from the next cycle.
- R4: A ready entry with no history match whose bank accepts is issued on the lowest free issue lane, in queue order (lane 0 holds the oldest). The issued address and tag appear on that lane, and the entry leaves the queue at the next edge while the remaining entries keep their order.
- R5: The bank of an address is block-address bits `[OFS+log2(NBANK)-1:OFS]` (bits 7:6 by default), and `bank_ok[b]` = 1 means bank b accepts. A ready entry whose bank does not accept is passed over and stays queued.
- R6: Scanning stops once `ISSUE_W` entries have been issued in a cycle. Entries after that point are neither issued nor dropped, and they are considered again in the next cycle.
- R7: Matching ignores the low `OFS` offset bits (64-byte blocks by default). A ready entry whose block matches the history, or matches a lane issued earlier in the same scan, is dropped: its tag appears on the lowest free drop lane, it is not issued, it uses no issue budget, and it leaves the queue at the next edge.
- R8: At most `DROP_W` entries are dropped per cycle. A further matching entry stays queued and the scan goes on past it.
- R9: The history records each issued block in lane order and holds the last `HIST` (16) of them, overwriting the oldest first. A block evicted from it is issued again, not dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Append a prefetch entry this cycle |
| enq_addr | input | AW | Physical address of the new entry |
| enq_id | input | ID_W | Tag of the new entry |
| enq_rdy | input | 1 | New entry's operands are already ready |
| q_full | output | 1 | Queue holds DEPTH entries |
| wake_valid | input | 1 | Mark queued entries with tag wake_id ready |
| wake_id | input | ID_W | Tag to wake |
| bank_ok | input | NBANK | Per-bank accept from the memory port |
| iss_valid | output | ISSUE_W | Prefetch request valid, one bit per lane |
| iss_addr | output | ISSUE_W*AW | Request addresses, lane 0 in the low bits |
| iss_id | output | ISSUE_W*ID_W | Request tags, lane 0 in the low bits |
| drop_valid | output | DROP_W | Completion notice for a dropped entry, per lane |
| drop_id | output | DROP_W*ID_W | Tags of dropped entries, lane 0 in the low bits |

## Verification
A stale or lost history entry shows up as soon as its block comes back to the port. A stale entry causes a drop notice where a request was due. A lost entry causes a second request for that block, so a repeated block is made to arrive both inside and just outside the 16-deep window. A compaction fault, such as a removed entry that lingers or a wrong tail slot, changes the tag or the lane order on the very next cycle the queue is scanned. Lane budgeting errors show up as extra or missing lanes in the cycle where several entries compete.

// File: rtl/pfq_pkg.sv
`timescale 1ns/1ps
package pfq_pkg;
  typedef enum logic [1:0] {
    ACT_KEEP  = 2'd0,
    ACT_ISSUE = 2'd1,
    ACT_DROP  = 2'd2
  } act_e;
endpackage

// File: rtl/pfq_store.sv
`timescale 1ns/1ps
// In-order entry storage; removed entries are squeezed out each edge.
module pfq_store #(
  parameter int AW    = 32,
  parameter int ID_W  = 4,
  parameter int DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enq_valid,
  input  logic [AW-1:0]               enq_addr,
  input  logic [ID_W-1:0]             enq_id,
  input  logic                        enq_rdy,
  input  logic                        wake_valid,
  input  logic [ID_W-1:0]             wake_id,
  input  logic [DEPTH-1:0]            remove,
  output logic [DEPTH-1:0]            q_vld,
  output logic [DEPTH-1:0]            q_rdy,
  output logic [DEPTH-1:0][AW-1:0]    q_addr,
  output logic [DEPTH-1:0][ID_W-1:0]  q_id,
  output logic                        full
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]           n_vld, n_rdy;
  logic [DEPTH-1:0][AW-1:0]   n_addr;
  logic [DEPTH-1:0][ID_W-1:0] n_id;
  logic [CW-1:0]              kept;
  logic                       upd_en;

  assign full   = &q_vld;
  assign upd_en = enq_valid | wake_valid | (|remove);

  always_comb begin
    n_vld  = '0;
    n_rdy  = '0;
    n_addr = '0;
    n_id   = '0;
    kept   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (q_vld[i] && !remove[i]) begin
        n_vld[kept[IW-1:0]]  = 1'b1;
        n_rdy[kept[IW-1:0]]  = q_rdy[i] | (wake_valid && (q_id[i] == wake_id));
        n_addr[kept[IW-1:0]] = q_addr[i];
        n_id[kept[IW-1:0]]   = q_id[i];
        kept = kept + CW'(1);
      end
    end
    if (enq_valid && !full) begin
      n_vld[kept[IW-1:0]]  = 1'b1;
      n_rdy[kept[IW-1:0]]  = enq_rdy;
      n_addr[kept[IW-1:0]] = enq_addr;
      n_id[kept[IW-1:0]]   = enq_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld  <= '0;
      q_rdy  <= '0;
      q_addr <= '0;
      q_id   <= '0;
    end else if (upd_en) begin
      q_vld  <= n_vld;
      q_rdy  <= n_rdy;
      q_addr <= n_addr;
      q_id   <= n_id;
    end
  end
endmodule

// File: rtl/pfq_hist.sv
`timescale 1ns/1ps
// FIFO of recently issued block addresses with a parallel lookup per queue slot.
module pfq_hist #(
  parameter int BAW     = 26,
  parameter int HIST    = 16,
  parameter int DEPTH   = 8,
  parameter int ISSUE_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DEPTH-1:0][BAW-1:0]     lk_blk,
  input  logic [ISSUE_W-1:0]            wr_vld,
  input  logic [ISSUE_W-1:0][BAW-1:0]   wr_blk,
  output logic [DEPTH-1:0]              hit
);
  localparam int HW = (HIST > 1) ? $clog2(HIST) : 1;

  logic [HIST-1:0]          h_vld, n_hvld;
  logic [HIST-1:0][BAW-1:0] h_blk, n_hblk;
  logic [HW-1:0]            wp, n_wp;
  logic                     wr_en;

  assign wr_en = |wr_vld;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hit[i] = 1'b0;
      for (int k = 0; k < HIST; k++) begin
        if (h_vld[k] && (h_blk[k] == lk_blk[i])) hit[i] = 1'b1;
      end
    end
  end

  always_comb begin
    n_hvld = h_vld;
    n_hblk = h_blk;
    n_wp   = wp;
    for (int j = 0; j < ISSUE_W; j++) begin
      if (wr_vld[j]) begin
        n_hvld[n_wp] = 1'b1;
        n_hblk[n_wp] = wr_blk[j];
        n_wp         = n_wp + HW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_vld <= '0;
      h_blk <= '0;
      wp    <= '0;
    end else if (wr_en) begin
      h_vld <= n_hvld;
      h_blk <= n_hblk;
      wp    <= n_wp;
    end
  end
endmodule

// File: rtl/pfq_pick.sv
`timescale 1ns/1ps
// Oldest-first scan: decides keep, issue or drop for each queue slot.
module pfq_pick
  import pfq_pkg::*;
#(
  parameter int AW      = 32,
  parameter int OFS     = 6,
  parameter int NBANK   = 4,
  parameter int DEPTH   = 8,
  parameter int ISSUE_W = 2,
  parameter int DROP_W  = 2,
  parameter int ID_W    = 4
) (
  input  logic [DEPTH-1:0]              q_vld,
  input  logic [DEPTH-1:0]              q_rdy,
  input  logic [DEPTH-1:0][AW-1:0]      q_addr,
  input  logic [DEPTH-1:0][ID_W-1:0]    q_id,
  input  logic [DEPTH-1:0]              hist_hit,
  input  logic [NBANK-1:0]              bank_ok,
  output logic [DEPTH-1:0]              remove,
  output logic [ISSUE_W-1:0]            iss_vld,
  output logic [ISSUE_W-1:0][AW-1:0]    iss_addr,
  output logic [ISSUE_W-1:0][ID_W-1:0]  iss_id,
  output logic [DROP_W-1:0]             drp_vld,
  output logic [DROP_W-1:0][ID_W-1:0]   drp_id
);
  localparam int BANK_W = $clog2(NBANK);
  localparam int IC     = $clog2(ISSUE_W + 1);
  localparam int DC     = $clog2(DROP_W + 1);

  act_e          act;
  logic          dup;
  logic [IC-1:0] ni;
  logic [DC-1:0] nd;

  always_comb begin
    remove   = '0;
    iss_vld  = '0;
    iss_addr = '0;
    iss_id   = '0;
    drp_vld  = '0;
    drp_id   = '0;
    ni       = '0;
    nd       = '0;
    act      = ACT_KEEP;
    dup      = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      act = ACT_KEEP;
      dup = hist_hit[i];
      for (int j = 0; j < ISSUE_W; j++) begin
        if (iss_vld[j] && (iss_addr[j][AW-1:OFS] == q_addr[i][AW-1:OFS])) dup = 1'b1;
      end
      if ((ni < IC'(ISSUE_W)) && q_vld[i] && q_rdy[i]) begin
        if (dup) begin
          if (nd < DC'(DROP_W)) act = ACT_DROP;
        end else if (bank_ok[q_addr[i][OFS +: BANK_W]]) begin
          act = ACT_ISSUE;
        end
      end
      if (act == ACT_DROP) begin
        for (int d = 0; d < DROP_W; d++) begin
          if (DC'(d) == nd) begin
            drp_vld[d] = 1'b1;
            drp_id[d]  = q_id[i];
          end
        end
        nd = nd + DC'(1);
      end else if (act == ACT_ISSUE) begin
        for (int j = 0; j < ISSUE_W; j++) begin
          if (IC'(j) == ni) begin
            iss_vld[j]  = 1'b1;
            iss_addr[j] = q_addr[i];
            iss_id[j]   = q_id[i];
          end
        end
        ni = ni + IC'(1);
      end
      remove[i] = (act != ACT_KEEP);
    end
  end
endmodule

// File: rtl/pfq_issue_filter.sv
`timescale 1ns/1ps
module pfq_issue_filter #(
  parameter int AW        = 32,
  parameter int BLK_BYTES = 64,
  parameter int HIST      = 16,
  parameter int DEPTH     = 8,
  parameter int ID_W      = 4,
  parameter int ISSUE_W   = 2,
  parameter int DROP_W    = 2,
  parameter int NBANK     = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enq_valid,
  input  logic [AW-1:0]             enq_addr,
  input  logic [ID_W-1:0]           enq_id,
  input  logic                      enq_rdy,
  output logic                      q_full,
  input  logic                      wake_valid,
  input  logic [ID_W-1:0]           wake_id,
  input  logic [NBANK-1:0]          bank_ok,
  output logic [ISSUE_W-1:0]        iss_valid,
  output logic [ISSUE_W*AW-1:0]     iss_addr,
  output logic [ISSUE_W*ID_W-1:0]   iss_id,
  output logic [DROP_W-1:0]         drop_valid,
  output logic [DROP_W*ID_W-1:0]    drop_id
);
  localparam int OFS = $clog2(BLK_BYTES);
  localparam int BAW = AW - OFS;

  logic [DEPTH-1:0]             q_vld, q_rdy, remove, hit;
  logic [DEPTH-1:0][AW-1:0]     q_addr;
  logic [DEPTH-1:0][ID_W-1:0]   q_id;
  logic [DEPTH-1:0][BAW-1:0]    lk_blk;
  logic [ISSUE_W-1:0][AW-1:0]   p_addr;
  logic [ISSUE_W-1:0][ID_W-1:0] p_id;
  logic [ISSUE_W-1:0][BAW-1:0]  wr_blk;
  logic [DROP_W-1:0][ID_W-1:0]  d_id;

  pfq_store #(.AW(AW), .ID_W(ID_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_addr(enq_addr), .enq_id(enq_id), .enq_rdy(enq_rdy),
    .wake_valid(wake_valid), .wake_id(wake_id), .remove(remove),
    .q_vld(q_vld), .q_rdy(q_rdy), .q_addr(q_addr), .q_id(q_id), .full(q_full)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_lk
    assign lk_blk[i] = q_addr[i][AW-1:OFS];
  end
  for (genvar j = 0; j < ISSUE_W; j++) begin : g_wr
    assign wr_blk[j] = p_addr[j][AW-1:OFS];
  end

  pfq_hist #(.BAW(BAW), .HIST(HIST), .DEPTH(DEPTH), .ISSUE_W(ISSUE_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .lk_blk(lk_blk),
    .wr_vld(iss_valid), .wr_blk(wr_blk), .hit(hit)
  );

  pfq_pick #(.AW(AW), .OFS(OFS), .NBANK(NBANK), .DEPTH(DEPTH),
             .ISSUE_W(ISSUE_W), .DROP_W(DROP_W), .ID_W(ID_W)) u_pick (
    .q_vld(q_vld), .q_rdy(q_rdy), .q_addr(q_addr), .q_id(q_id),
    .hist_hit(hit), .bank_ok(bank_ok), .remove(remove),
    .iss_vld(iss_valid), .iss_addr(p_addr), .iss_id(p_id),
    .drp_vld(drop_valid), .drp_id(d_id)
  );

  assign iss_addr = p_addr;
  assign iss_id   = p_id;
  assign drop_id  = d_id;
endmodule

// File: rtl/pfq_chk.sv
`timescale 1ns/1ps
module pfq_chk #(
  parameter int AW        = 32,
  parameter int BLK_BYTES = 64,
  parameter int NBANK     = 4,
  parameter int ISSUE_W   = 2,
  parameter int DROP_W    = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NBANK-1:0]      bank_ok,
  input logic [ISSUE_W-1:0]    iss_valid,
  input logic [ISSUE_W*AW-1:0] iss_addr,
  input logic [DROP_W-1:0]     drop_valid
);
  localparam int OFS    = $clog2(BLK_BYTES);
  localparam int BAW    = AW - OFS;
  localparam int BANK_W = $clog2(NBANK);

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (iss_valid == '0) && (drop_valid == '0));

  assert_issue_lanes_packed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid & (iss_valid + 1'b1)) == '0);

  assert_drop_lanes_packed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_valid & (drop_valid + 1'b1)) == '0);

  assert_no_reissue_R9: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[0] |=> !(iss_valid[0] && (iss_addr[OFS +: BAW] == $past(iss_addr[OFS +: BAW]))));

  for (genvar j = 0; j < ISSUE_W; j++) begin : g_lane
    assert_bank_accepts_R5: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[j] |-> bank_ok[iss_addr[j*AW+OFS +: BANK_W]]);
    for (genvar k = j + 1; k < ISSUE_W; k++) begin : g_pair
      assert_lanes_distinct_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid[j] && iss_valid[k]) |-> (iss_addr[j*AW+OFS +: BAW] != iss_addr[k*AW+OFS +: BAW]));
    end
  end
endmodule

bind pfq_issue_filter pfq_chk #(
  .AW(AW), .BLK_BYTES(BLK_BYTES), .NBANK(NBANK), .ISSUE_W(ISSUE_W), .DROP_W(DROP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_ok(bank_ok),
  .iss_valid(iss_valid), .iss_addr(iss_addr), .drop_valid(drop_valid)
);

// File: tb/tb_pfq_issue_filter.sv
`timescale 1ns/1ps
module tb_pfq_issue_filter;
  localparam int AW = 32, ID_W = 4, ISSUE_W = 2, DROP_W = 2, NBANK = 4, DEPTH = 8;

  logic clk, rst_n;
  logic enq_valid, enq_rdy, wake_valid, q_full;
  logic [AW-1:0] enq_addr;
  logic [ID_W-1:0] enq_id, wake_id;
  logic [NBANK-1:0] bank_ok;
  logic [ISSUE_W-1:0] iss_valid;
  logic [ISSUE_W*AW-1:0] iss_addr;
  logic [ISSUE_W*ID_W-1:0] iss_id;
  logic [DROP_W-1:0] drop_valid;
  logic [DROP_W*ID_W-1:0] drop_id;

  int total = 0, bad = 0;
  bit done = 0;

  pfq_issue_filter dut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_addr(enq_addr),
    .enq_id(enq_id), .enq_rdy(enq_rdy), .q_full(q_full), .wake_valid(wake_valid),
    .wake_id(wake_id), .bank_ok(bank_ok), .iss_valid(iss_valid), .iss_addr(iss_addr),
    .iss_id(iss_id), .drop_valid(drop_valid), .drop_id(drop_id)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [7:0] b0, b1, b2, b3;
    logic [3:0] rdy;
    logic [3:0] ok;
    logic [1:0] iv;
    logic [3:0] i0, i1;
    logic [1:0] dv;
    logic [3:0] d0, d1;
  } row_t;

  // Four entries with tags 0..3 in queue order; block numbers and bank-accept masks.
  localparam row_t ROWS [6] = '{
    '{8'd1, 8'd2, 8'd3, 8'd4, 4'b1111, 4'b1111, 2'b11, 4'd0, 4'd1, 2'b00, 4'd0, 4'd0},
    '{8'd1, 8'd2, 8'd3, 8'd4, 4'b1110, 4'b1111, 2'b11, 4'd1, 4'd2, 2'b00, 4'd0, 4'd0},
    '{8'd1, 8'd2, 8'd3, 8'd5, 4'b1111, 4'b1011, 2'b11, 4'd0, 4'd2, 2'b00, 4'd0, 4'd0},
    '{8'd1, 8'd1, 8'd2, 8'd3, 4'b1111, 4'b1111, 2'b11, 4'd0, 4'd2, 2'b01, 4'd1, 4'd0},
    '{8'd1, 8'd2, 8'd3, 8'd4, 4'b1111, 4'b0000, 2'b00, 4'd0, 4'd0, 2'b00, 4'd0, 4'd0},
    '{8'd5, 8'd5, 8'd5, 8'd5, 4'b1111, 4'b1111, 2'b01, 4'd0, 4'd0, 2'b11, 4'd1, 4'd2}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; enq_valid = 1'b0; enq_addr = '0; enq_id = '0; enq_rdy = 1'b0;
    wake_valid = 1'b0; wake_id = '0; bank_ok = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Called at a falling edge; returns at the next falling edge with the entry stored.
  task automatic push(input logic [AW-1:0] a, input logic [ID_W-1:0] id, input logic r);
    enq_valid = 1'b1; enq_addr = a; enq_id = id; enq_rdy = r;
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  initial begin
    #4000000;
    total++; bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R1: empty after reset, even with every bank accepting
    do_reset();
    bank_ok = 4'b1111;
    #5;
    check("R1 iss_valid after reset", 64'(iss_valid), 64'd0);
    check("R1 drop_valid after reset", 64'(drop_valid), 64'd0);
    check("R1 q_full after reset", 64'(q_full), 64'd0);
    @(negedge clk);

    // Table walk: R3 R4 R5 R6 R7 R8 scan outcomes in a single cycle
    for (int r = 0; r < 6; r++) begin
      do_reset();
      push({ROWS[r].b0, 6'd0} | 32'd0, 4'd0, ROWS[r].rdy[0]);
      push({ROWS[r].b1, 6'd4} | 32'd0, 4'd1, ROWS[r].rdy[1]);
      push({ROWS[r].b2, 6'd8} | 32'd0, 4'd2, ROWS[r].rdy[2]);
      push({ROWS[r].b3, 6'd12} | 32'd0, 4'd3, ROWS[r].rdy[3]);
      bank_ok = ROWS[r].ok;
      #5;
      check($sformatf("R4 R6 row%0d issue lanes", r), 64'(iss_valid), 64'(ROWS[r].iv));
      if (ROWS[r].iv[0]) check($sformatf("R4 R5 row%0d lane0 tag", r), 64'(iss_id[3:0]), 64'(ROWS[r].i0));
      if (ROWS[r].iv[1]) check($sformatf("R3 R5 row%0d lane1 tag", r), 64'(iss_id[7:4]), 64'(ROWS[r].i1));
      check($sformatf("R7 R8 row%0d drop lanes", r), 64'(drop_valid), 64'(ROWS[r].dv));
      if (ROWS[r].dv[0]) check($sformatf("R7 row%0d drop0 tag", r), 64'(drop_id[3:0]), 64'(ROWS[r].d0));
      if (ROWS[r].dv[1]) check($sformatf("R8 row%0d drop1 tag", r), 64'(drop_id[7:4]), 64'(ROWS[r].d1));
      @(negedge clk);
    end

    // R6: entries beyond the budget go out next cycle; R4 issued ones are gone
    do_reset();
    push(32'h40, 4'd0, 1'b1); push(32'h80, 4'd1, 1'b1);
    push(32'hC0, 4'd2, 1'b1); push(32'h100, 4'd3, 1'b1);
    bank_ok = 4'b1111;
    @(negedge clk); #5;
    check("R6 second cycle lanes", 64'(iss_valid), 64'b11);
    check("R6 second cycle tags", 64'(iss_id), 64'h32);
    check("R4 second cycle address lane1", 64'(iss_addr[63:32]), 64'h100);
    @(negedge clk); #5;
    check("R4 queue empty afterwards", 64'(iss_valid), 64'd0);
    @(negedge clk);

    // R7: same block, different offset, is dropped against history
    do_reset();
    bank_ok = 4'b1111;
    push(32'd640, 4'd0, 1'b1);
    @(negedge clk);
    push(32'd648, 4'd1, 1'b1);
    #5;
    check("R7 history drop valid", 64'(drop_valid), 64'b01);
    check("R7 history drop tag", 64'(drop_id[3:0]), 64'd1);
    check("R7 no issue on hit", 64'(iss_valid), 64'd0);
    @(negedge clk); #5;
    check("R7 dropped entry gone", 64'(drop_valid), 64'd0);
    @(negedge clk);

    // R9: 17 distinct blocks evict the first; the second still filters
    do_reset();
    bank_ok = 4'b1111;
    for (int b = 20; b <= 36; b++) push(32'(b * 64), 4'(b), 1'b1);
    @(negedge clk); #5;
    check("R9 idle after fill", 64'(iss_valid), 64'd0);
    @(negedge clk);
    push(32'(21 * 64 + 32), 4'd1, 1'b1);
    #5;
    check("R9 still-held block dropped", 64'(drop_valid), 64'b01);
    check("R9 still-held block not issued", 64'(iss_valid), 64'd0);
    @(negedge clk);
    push(32'(20 * 64), 4'd2, 1'b1);
    #5;
    check("R9 evicted block issued", 64'(iss_valid), 64'b01);
    check("R9 evicted block tag", 64'(iss_id[3:0]), 64'd2);
    check("R9 evicted block not dropped", 64'(drop_valid), 64'd0);
    @(negedge clk);

    // R2: full flag and ignored enqueue; R3: wake by tag
    do_reset();
    for (int k = 0; k < DEPTH; k++) push(32'((k + 1) * 64), 4'(k), 1'b0);
    #5;
    check("R2 full after DEPTH pushes", 64'(q_full), 64'd1);
    @(negedge clk);
    push(32'(50 * 64), 4'd9, 1'b1);
    bank_ok = 4'b1111;
    #5;
    check("R2 enqueue while full ignored", 64'(iss_valid), 64'd0);
    check("R3 unready entries held", 64'(q_full), 64'd1);
    @(negedge clk);
    wake_valid = 1'b1; wake_id = 4'd9;
    @(negedge clk);
    wake_valid = 1'b0;
    #5;
    check("R2 ignored tag absent", 64'(iss_valid), 64'd0);
    @(negedge clk);
    wake_valid = 1'b1; wake_id = 4'd3;
    @(negedge clk);
    wake_valid = 1'b0;
    #5;
    check("R3 woken entry issues", 64'(iss_valid), 64'b01);
    check("R3 woken entry tag", 64'(iss_id[3:0]), 64'd3);
    check("R3 woken entry address", 64'(iss_addr[31:0]), 64'd256);
    @(negedge clk); #5;
    check("R2 full clears after removal", 64'(q_full), 64'd0);
    @(negedge clk);
    wake_valid = 1'b1; wake_id = 4'd6;
    @(negedge clk);
    wake_valid = 1'b0;
    #5;
    check("R4 order kept after squeeze", 64'(iss_addr[31:0]), 64'd448);
    @(negedge clk);

    finish_run();
  end
endmodule